// File: doc/BRIEF.md
# Two-Line Debug State Serializer

This block streams a snapshot of three internal synthesizer quantities out on two serial pins while a particular host-bus condition is held. The snapshot holds a 9-bit phase value, a 7-bit envelope value and a 9-bit channel output value. Each frame is 18 bit periods long. A bit period is four master-clock cycles, set by a free-running divider.

The first serial line carries the phase value and then six of the seven envelope bits. The second line carries the channel value. Both lines are padded with zeros to the end of the frame. All three values are captured together at the start of every frame, so a frame never mixes old and new data. When the bus condition goes away, output-enable drops and both lines return to zero. When the condition comes back, a new frame begins at slot 0.

Top module: `state_probe_serializer`

## Requirements
- R1: The serializer is enabled only while `sel_n` is 0, `wen_n` is 1 and `port_a` is 0. Any other combination keeps `sdo_oe`, `sdo0` and `sdo1` at 0.
- R2: A divide-by-4 prescaler runs freely from reset. It produces one tick every 4 clock cycles, and its first tick falls on the fourth clock edge of the prescaler's run. Slot changes and the start of output happen only on tick edges.
- R3: A frame is 18 slots, numbered 0 to 17. After slot 17 the count goes back to 0 and continues while the enable holds.
- R4: In slots 0 to 8, `sdo0` carries phase bits 8 down to 0, most significant bit first (slot k carries bit 8-k).
- R5: In slots 9 to 14, `sdo0` carries envelope bits 6, 5, 4, 2, 1 and 0 in that order. Envelope bit 3 is never sent.
- R6: In slots 15 to 17, `sdo0` is 0.
- R7: In slots 0 to 8, `sdo1` carries channel bits 8 down to 0, most significant bit first. In slots 9 to 17, `sdo1` is 0.
- R8: All three values are captured on the tick that enters slot 0. Changes to the inputs later in the frame do not affect that frame.
- R9: If the enable is lost, `sdo_oe`, `sdo0` and `sdo1` are 0 after the next clock edge. The next enabled tick starts again at slot 0 with a fresh capture.
- R10: While reset is held, and after it is released, `sdo_oe`, `sdo0` and `sdo1` are 0 until an enabled tick occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| wen_n | input | 1 | Write enable, active low; must be high for debug output |
| port_a | input | 1 | Address line; must be low for debug output |
| phase_i | input | 9 | Phase value to be sampled |
| env_i | input | 7 | Envelope value to be sampled |
| chan_i | input | 9 | Channel output value to be sampled |
| sdo0 | output | 1 | Serial line carrying phase, then envelope |
| sdo1 | output | 1 | Serial line carrying channel output |
| sdo_oe | output | 1 | High while a frame is being driven |

## Verification
Frames are run with all-ones, alternating-bit and single-bit values. These patterns separate the bit order on each line, show that only envelope bit 3 is dropped, and show that the zero padding lands in the right slots. The stimulus also changes the inputs in the middle of a frame, which tells a snapshot taken at slot 0 apart from live sampling. Each of the three bus pins is broken on its own to cover the enable decode. The enable is dropped and restored at several prescaler phases to test restart at slot 0 and tick-aligned starts.

// File: rtl/probe_pkg.sv
package probe_pkg;
  parameter int PH_W      = 9;
  parameter int ENV_W     = 7;
  parameter int CH_W      = 9;
  parameter int ENV_SKIP  = 3;
  parameter int FRAME_LEN = 18;
  parameter int DIV       = 4;

  localparam int SLOT_W    = $clog2(FRAME_LEN);
  localparam int ENV_SENT  = ENV_W - 1;
  localparam int L0_USED   = PH_W + ENV_SENT;

  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/probe_prescaler.sv
module probe_prescaler #(
  parameter int DIV = probe_pkg::DIV
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/probe_sequencer.sv
module probe_sequencer
  import probe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  tick_i,
  output logic  active_o,
  output slot_t slot_o,
  output logic  cap_o
);
  localparam slot_t LAST_SLOT = slot_t'(FRAME_LEN - 1);

  logic  active_q, active_d;
  slot_t slot_q, slot_d;
  logic  cap_d;

  always_comb begin
    active_d = active_q;
    slot_d   = slot_q;
    cap_d    = 1'b0;
    if (!en_i) begin
      active_d = 1'b0;
      slot_d   = '0;
    end else if (tick_i) begin
      if (!active_q) begin
        active_d = 1'b1;
        slot_d   = '0;
        cap_d    = 1'b1;
      end else if (slot_q == LAST_SLOT) begin
        slot_d   = '0;
        cap_d    = 1'b1;
      end else begin
        slot_d   = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
    end else begin
      active_q <= active_d;
      slot_q   <= slot_d;
    end
  end

  assign active_o = active_q;
  assign slot_o   = slot_q;
  assign cap_o    = cap_d;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST_SLOT); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && active_q && slot_q == LAST_SLOT) |=> (slot_q == '0)); // R3
  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> ($stable(slot_q) && $stable(active_q))); // R2
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && en_i && tick_i) |=> (active_q && slot_q == '0)); // R9
endmodule

// File: rtl/probe_framer.sv
module probe_framer
  import probe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             active_i,
  input  slot_t            slot_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [ENV_W-1:0] env_i,
  input  logic [CH_W-1:0]  chan_i,
  output logic             bit0_o,
  output logic             bit1_o
);
  logic [PH_W-1:0]     phase_q;
  logic [ENV_SENT-1:0] env_q;
  logic [CH_W-1:0]     chan_q;
  logic [ENV_SENT-1:0] env_pack;

  // drop the skipped envelope bit, keep the rest in descending order
  for (genvar g = 0; g < ENV_SENT; g++) begin : g_env_pack
    if (g < ENV_SKIP) begin : g_low
      assign env_pack[g] = env_i[g];
    end else begin : g_high
      assign env_pack[g] = env_i[g+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      env_q   <= '0;
      chan_q  <= '0;
    end else if (cap_i) begin
      phase_q <= phase_i;
      env_q   <= env_pack;
      chan_q  <= chan_i;
    end
  end

  logic [FRAME_LEN-1:0] line0_vec, line1_vec;

  assign line0_vec = {phase_q, env_q, {(FRAME_LEN - L0_USED){1'b0}}};
  assign line1_vec = {chan_q, {(FRAME_LEN - CH_W){1'b0}}};

  logic [SLOT_W:0] idx;
  always_comb begin
    idx    = (SLOT_W+1)'(FRAME_LEN - 1) - {1'b0, slot_i};
    bit0_o = active_i & line0_vec[idx];
    bit1_o = active_i & line1_vec[idx];
  end

  AST_L0_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && slot_i >= slot_t'(L0_USED)) |-> !bit0_o); // R6
  AST_L1_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && slot_i >= slot_t'(CH_W)) |-> !bit1_o); // R7
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(phase_q) && $stable(env_q) && $stable(chan_q))); // R8
endmodule

// File: rtl/state_probe_serializer.sv
module state_probe_serializer
  import probe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             wen_n,
  input  logic             port_a,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [ENV_W-1:0] env_i,
  input  logic [CH_W-1:0]  chan_i,
  output logic             sdo0,
  output logic             sdo1,
  output logic             sdo_oe
);
  logic rst_s1_q, rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic  rst_int_n;
  logic  dbg_en;
  logic  tick;
  logic  active;
  logic  cap;
  slot_t slot;

  assign rst_int_n = rst_s2_q;
  assign dbg_en    = !sel_n && wen_n && !port_a;

  probe_prescaler #(.DIV(DIV)) u_presc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (tick)
  );

  probe_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en_i     (dbg_en),
    .tick_i   (tick),
    .active_o (active),
    .slot_o   (slot),
    .cap_o    (cap)
  );

  probe_framer u_frm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_i    (cap),
    .active_i (active),
    .slot_i   (slot),
    .phase_i  (phase_i),
    .env_i    (env_i),
    .chan_i   (chan_i),
    .bit0_o   (sdo0),
    .bit1_o   (sdo1)
  );

  assign sdo_oe = active;

  AST_EN_DROP: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dbg_en |=> !sdo_oe); // R1
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sdo_oe |-> (!sdo0 && !sdo1)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> !sdo_oe); // R10
endmodule

// File: tb/state_probe_serializer_tb_top.sv
module state_probe_serializer_tb_top;
  logic clk = 1'b0;
  logic rst_n, sel_n, wen_n, port_a;
  logic [8:0] phase_i, chan_i;
  logic [6:0] env_i;
  logic sdo0, sdo1, sdo_oe;

  always #5 clk = ~clk;

  state_probe_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wen_n(wen_n), .port_a(port_a),
    .phase_i(phase_i), .env_i(env_i), .chan_i(chan_i),
    .sdo0(sdo0), .sdo1(sdo1), .sdo_oe(sdo_oe)
  );

  int n_vec = 0, n_bad = 0, cycles = 0;
  string scen = "R10";

  // behavioural model
  int m_rel = 0, m_run = 0, m_slot = 0;
  bit m_act = 0;
  bit l0[$], l1[$];

  task automatic snap();
    l0 = {}; l1 = {};
    for (int b = 8; b >= 0; b--) l0.push_back(phase_i[b]);
    for (int b = 6; b >= 0; b--) if (b != 3) l0.push_back(env_i[b]);
    while (l0.size() < 18) l0.push_back(1'b0);
    for (int b = 8; b >= 0; b--) l1.push_back(chan_i[b]);
    while (l1.size() < 18) l1.push_back(1'b0);
  endtask

  task automatic model_edge();
    bit en, tk;
    if (!rst_n) begin m_rel = 0; m_run = 0; m_act = 0; m_slot = 0; return; end
    m_rel++;
    if (m_rel < 3) return;
    m_run++;
    tk = (m_run % 4) == 0;
    en = !sel_n && wen_n && !port_a;
    if (!en) begin m_act = 0; m_slot = 0; end
    else if (tk) begin
      if (!m_act) begin m_act = 1; m_slot = 0; snap(); end
      else begin m_slot = (m_slot + 1) % 18; if (m_slot == 0) snap(); end
    end
  endtask

  task automatic compare();
    bit e0, e1;
    string t0;
    e0 = m_act ? l0[m_slot] : 1'b0;
    e1 = m_act ? l1[m_slot] : 1'b0;
    if (!m_act) t0 = "R1";
    else if (m_slot < 9) t0 = "R4";
    else if (m_slot < 15) t0 = "R5";
    else t0 = "R6";
    n_vec++;
    if (sdo_oe !== m_act) begin
      n_bad++;
      $display("FAIL R1 [%s] sdo_oe slot %0d: got %b exp %b", scen, m_slot, sdo_oe, m_act);
    end
    if (sdo0 !== e0) begin
      n_bad++;
      $display("FAIL %s [%s] sdo0 slot %0d: got %b exp %b", t0, scen, m_slot, sdo0, e0);
    end
    if (sdo1 !== e1) begin
      n_bad++;
      $display("FAIL R7 [%s] sdo1 slot %0d: got %b exp %b", scen, m_slot, sdo1, e1);
    end
  endtask

  // one clock: inputs already driven; wait for edge, model it, check
  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_edge();
      compare();
      cycles++;
    end
  endtask

  task automatic bus(bit s, bit w, bit a);
    sel_n = s; wen_n = w; port_a = a;
  endtask

  task automatic vals(logic [8:0] p, logic [6:0] e, logic [8:0] c);
    phase_i = p; env_i = e; chan_i = c;
  endtask

  initial begin
    rst_n = 0; bus(1, 0, 1); vals(9'h1FF, 7'h7F, 9'h1FF);
    scen = "R10";
    step(5);
    rst_n = 1;
    step(10);
    // R1: each pin wrong on its own
    scen = "R1";
    bus(1, 1, 0); step(12);
    bus(0, 0, 0); step(12);
    bus(0, 1, 1); step(12);
    // R4 R5 R6 R7 R3: all ones, several frames
    scen = "R3";
    bus(0, 1, 0); step(4 * 18 * 3 + 6);
    // alternating patterns
    scen = "R4";
    vals(9'h155, 7'h55, 9'h0AA); bus(1, 1, 0); step(3); bus(0, 1, 0); step(4 * 18 * 2 + 4);
    // R5: only the skipped bit set, then all but it
    scen = "R5";
    vals(9'h000, 7'h08, 9'h000); bus(1, 1, 0); step(1); bus(0, 1, 0); step(4 * 19);
    vals(9'h001, 7'h77, 9'h100); bus(1, 1, 0); step(2); bus(0, 1, 0); step(4 * 19);
    // R8: inputs change mid-frame
    scen = "R8";
    vals(9'h0F0, 7'h3C, 9'h10F); bus(1, 1, 0); step(1); bus(0, 1, 0); step(4 * 5 + 2);
    vals(9'h10F, 7'h43, 9'h0F0); step(4 * 20);
    // R9 R2: drop and restore at each prescaler phase
    scen = "R9";
    for (int ph = 0; ph < 4; ph++) begin
      vals(9'h1A5 ^ 9'(ph), 7'h2D, 9'h05A); bus(0, 1, 0); step(4 * 7 + ph);
      bus(0, 1, 1); step(1 + ph);
      scen = "R2";
      bus(0, 1, 0); step(4 * 19);
      scen = "R9";
    end
    // R10: reset in the middle of a frame
    scen = "R10";
    rst_n = 0; step(3); rst_n = 1; step(4 * 20);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule